// File: doc/BRIEF.md
# Five-Function Integer ALU

A purely combinational integer arithmetic and logic unit of parameterized width. Two operands and a three-bit function code go in. An N-bit result comes out, together with a zero flag and a signed overflow flag. There is no clock and no reset. The result settles as soon as the inputs are stable, so the unit can sit directly in an execute stage between pipeline registers.

The function code has two parts. The top bit selects whether the second operand is used as is or bitwise inverted. The same bit also feeds the carry input of the single shared adder, so addition and subtraction reuse one carry chain. The low two bits pick among the AND, OR and adder paths, plus a set-if-less-than path. Set-if-less-than places the sign bit of the raw difference in bit 0 of the result and fills the upper bits with zeros.

Top module: `int_alu5`

## Requirements
- R1: Code 000 gives Y = A & B; code 100 gives Y = A & ~B.
- R2: Code 001 gives Y = A | B; code 101 gives Y = A | ~B.
- R3: Code 010 gives Y = (A + B) modulo 2^N.
- R4: Code 110 gives Y = (A - B) modulo 2^N, formed as A + ~B + 1.
- R5: Code 111 gives Y[0] equal to bit N-1 of (A - B) modulo 2^N, with Y[N-1:1] all zero. No overflow correction is applied.
- R6: Code 011 gives Y = A & B, the same as code 000.
- R7: The zero flag is 1 exactly when every bit of Y is 0, for every code.
- R8: For codes 010 and 110, the overflow flag is 1 exactly when the two adder inputs (A and B, or A and ~B) share a sign bit and the sum's sign bit differs from it.
- R9: The overflow flag is 0 for every code other than 010 and 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | First operand A |
| opb_i | input | WIDTH | Second operand B |
| func_i | input | 3 | Function code; bit 2 inverts B and is the adder carry-in |
| res_o | output | WIDTH | Result Y |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench goes after the signed limits. Adding the most positive value to one, or subtracting one from the most negative value, must raise the overflow flag. A design that took overflow from the unsigned carry-out would miss these cases, and would also raise the flag on harmless wraps such as -1 + 1. Set-if-less-than is driven with operand pairs whose true difference overflows. A design that "corrected" the comparison would return the opposite bit to the one the raw sign rule defines. The codes that select logic paths (011, 100 and 101) are also checked: a decoder that treated 011 as an illegal code, or dropped the inversion on 100 and 101, shows up as a wrong result there. Equal operands under subtraction check that the zero flag tracks the result.

// File: rtl/int_alu5_pkg.sv
package int_alu5_pkg;
   localparam int FUNC_W = 3;
   localparam logic [1:0] SEL_AND = 2'b00;
   localparam logic [1:0] SEL_OR  = 2'b01;
   localparam logic [1:0] SEL_SUM = 2'b10;
   localparam logic [1:0] SEL_SLT = 2'b11;
   localparam logic [FUNC_W-1:0] CODE_ADD = 3'b010;
   localparam logic [FUNC_W-1:0] CODE_SUB = 3'b110;
   localparam logic [FUNC_W-1:0] CODE_SLT = 3'b111;
   localparam logic [FUNC_W-1:0] CODE_AN2 = 3'b011;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] b_i,
   input  logic             inv_i,
   output logic [WIDTH-1:0] bb_o
);
   localparam logic [WIDTH-1:0] ALL_ONES = '1;
   assign bb_o = b_i ^ (inv_i ? ALL_ONES : '0);
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
            assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
         end
         assign ovf_o = carry[WIDTH] ^ carry[MSB];
      end else begin : g_behav
         assign sum_o = a_i + b_i + {{MSB{1'b0}}, cin_i};
         assign ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
      end
   endgenerate
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o
);
   assign and_o = a_i & b_i;
   assign or_o  = a_i | b_i;
endmodule

// File: rtl/int_alu5.sv
module int_alu5 #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic [2:0]       func_i,
   output logic [WIDTH-1:0] res_o,
   output logic             zero_o,
   output logic             ovf_o
);
   import int_alu5_pkg::*;

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_chk
         $error("int_alu5: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] bb, and_v, or_v, sum_v, slt_v;
   logic             add_ovf;

   alu_operand_prep #(.WIDTH(WIDTH)) prep_i (
      .b_i(opb_i), .inv_i(func_i[2]), .bb_o(bb));

   alu_logic_unit #(.WIDTH(WIDTH)) logic_i (
      .a_i(opa_i), .b_i(bb), .and_o(and_v), .or_o(or_v));

   alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) adder_i (
      .a_i(opa_i), .b_i(bb), .cin_i(func_i[2]), .sum_o(sum_v), .ovf_o(add_ovf));

   assign slt_v = {{MSB{1'b0}}, sum_v[MSB]};

   always_comb begin
      unique case (func_i[1:0])
         SEL_AND: res_o = and_v;
         SEL_OR:  res_o = or_v;
         SEL_SUM: res_o = sum_v;
         SEL_SLT: res_o = func_i[2] ? slt_v : and_v;
         default: res_o = and_v;
      endcase
   end

   assign zero_o = (res_o == '0);
   assign ovf_o  = (func_i[1:0] == SEL_SUM) ? add_ovf : 1'b0;

   logic [WIDTH-1:0] ref_diff;
   assign ref_diff = opa_i - opb_i;

   always_comb begin
      if (func_i == CODE_SLT) begin
         AST_SLT_UPPER_CLEAR: assert (res_o[MSB:1] == '0 && res_o[0] == ref_diff[MSB]) // R5
            else $error("SLT result malformed");
      end
      if (func_i[1:0] != SEL_SUM) begin
         AST_NO_OVERFLOW: assert (!ovf_o) // R9
            else $error("overflow on non-arith code");
      end
      if (func_i == CODE_SUB && opa_i == opb_i) begin
         AST_SUB_EQ_ZERO: assert (zero_o) // R7
            else $error("equal operands did not give zero");
      end
      if (ovf_o) begin
         AST_OVF_SIGNS: assert (opa_i[MSB] == bb[MSB] && res_o[MSB] != opa_i[MSB]) // R8
            else $error("overflow without sign condition");
      end
      if (func_i == CODE_AN2) begin
         AST_CODE3_AND: assert (res_o == (opa_i & opb_i)) // R6
            else $error("code 011 not AND");
      end
   end
endmodule

// File: tb/int_alu5_tb_top.sv
module int_alu5_tb_top;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [W-1:0] a, b, y;
   logic [2:0]   f;
   logic         z, v;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int_alu5 #(.WIDTH(W)) dut_i (
      .opa_i(a), .opb_i(b), .func_i(f), .res_o(y), .zero_o(z), .ovf_o(v));

   function automatic logic [W-1:0] exp_y(input logic [W-1:0] x, input logic [W-1:0] q,
                                          input logic [2:0] c);
      logic [W-1:0] d;
      d = x - q;
      case (c)
         3'b000, 3'b011: return x & q;
         3'b100:         return x & ~q;
         3'b001:         return x | q;
         3'b101:         return x | ~q;
         3'b010:         return x + q;
         3'b110:         return d;
         default:        return {{(W-1){1'b0}}, d[W-1]};
      endcase
   endfunction

   function automatic logic exp_v(input logic [W-1:0] x, input logic [W-1:0] q,
                                  input logic [2:0] c);
      logic [W-1:0] s;
      if (c == 3'b010) begin
         s = x + q;
         return (x[W-1] == q[W-1]) && (s[W-1] != x[W-1]);
      end
      if (c == 3'b110) begin
         s = x - q;
         return (x[W-1] != q[W-1]) && (s[W-1] != x[W-1]);
      end
      return 1'b0;
   endfunction

   function automatic string req_of(input logic [2:0] c);
      case (c)
         3'b000, 3'b100: return "R1";
         3'b001, 3'b101: return "R2";
         3'b010:         return "R3";
         3'b110:         return "R4";
         3'b111:         return "R5";
         default:        return "R6";
      endcase
   endfunction

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] q, input logic [2:0] c);
      logic [W-1:0] ey;
      logic         ev;
      @(posedge clk);
      a = x; b = q; f = c;
      @(negedge clk);
      ey = exp_y(x, q, c);
      ev = exp_v(x, q, c);
      checks++;
      if (y !== ey) begin
         errors++;
         $display("FAIL %s code=%b a=%h b=%h y=%h exp=%h", req_of(c), c, x, q, y, ey);
      end
      checks++;
      if (z !== (ey == '0)) begin
         errors++;
         $display("FAIL R7 code=%b a=%h b=%h zero=%b exp=%b", c, x, q, z, (ey == '0));
      end
      checks++;
      if (v !== ev) begin
         errors++;
         $display("FAIL %s code=%b a=%h b=%h ovf=%b exp=%b",
                  (c[1:0] == 2'b10) ? "R8" : "R9", c, x, q, v, ev);
      end
   endtask

   initial begin
      a = '0; b = '0; f = 3'b000;
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle state: zero inputs, AND code gives zero result and flag
      apply('0, '0, 3'b000);
      // corner cases
      for (int c = 0; c < 8; c++) begin
         apply(32'h7FFF_FFFF, 32'h0000_0001, c[2:0]);  // R3 R8 positive overflow
         apply(32'h8000_0000, 32'h0000_0001, c[2:0]);  // R4 R5 negative overflow
         apply(32'hFFFF_FFFF, 32'h0000_0001, c[2:0]);  // carry-out without overflow
         apply(32'h8000_0000, 32'h8000_0000, c[2:0]);
         apply(32'h1234_5678, 32'h1234_5678, c[2:0]);  // R7 equal operands
         apply(32'h7FFF_FFFF, 32'h8000_0000, c[2:0]);  // R5 raw sign vs true order
         apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, c[2:0]);  // R1 R2 R6 patterns
         apply('0, '1, c[2:0]);
      end
      // constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [W-1:0] x, q;
         x = $urandom();
         q = $urandom();
         if (n % 7 == 0) q = x;
         if (n % 11 == 0) x = {x[W-1], {(W-1){~x[W-1]}}};
         apply(x, q, 3'($urandom_range(0, 7)));
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule